// File: doc/BRIEF.md
# Pause-Pulse Reader Bit Transmitter

This block sends one reader-to-card frame of up to 32 bits by switching a carrier-enable output. Every bit opens with a short carrier-off pause and then holds the carrier on. The total length of the bit carries its value: a 1 bit is long and a 0 bit is short. Before each bit goes out, the data bit is XORed with one bit from an external keystream source. The block fetches that bit through a ready/advance handshake.

All timing comes from a free-running tick counter that steps once every `TICK_DIV` clocks. The bit, pause and gap lengths are given in microseconds and converted to ticks using the `TICK_NUM/TICK_DEN` ticks-per-microsecond parameters. The host supplies a start strobe, a frame word, a bit count and the shared end-of-last-frame timestamp. Every deadline is built by adding durations to that timestamp, never to the current time, so no rounding or latency drift builds up over a frame. When the frame ends, the block returns the new end timestamp so the next receive or transmit window can be scheduled from it. The deadline comparison is wrap-safe, so frames may straddle the 32-bit counter rollover.

Top module: `ptx_pause_tx`

## Requirements
- R1: After reset the carrier is on, `busy`, `done` and `ks_adv` are 0, `frame_end` is 0 and `tick_now` equals `TICK_INIT`.
- R2: The first carrier-off pause of an accepted frame starts when `tick_now` reaches `last_end` plus the 220 µs turnaround gap (330 ticks by default).
- R3: Each bit's carrier-off pause lasts 20 µs (30 ticks), measured from the bit's scheduled start.
- R4: A transmitted 1 occupies 100 µs (150 ticks) from its pause start to the next pause start, and a transmitted 0 occupies 60 µs (90 ticks). The carrier is on for the rest of the bit.
- R5: Bits go out starting from bit 0 of `frame_data`, one bit per bit period. The number of bits sent is `frame_len`, limited to 32. A length of 0 sends only the end pause.
- R6: The bit on air is the data bit XOR `ks_bit`, where `ks_bit` is sampled when the bit's pause begins. `ks_adv` pulses for one cycle, in the same cycle the carrier first goes low for that bit, once per bit. A bit does not start while `ks_ready` is low, and its pause still ends at the scheduled deadline.
- R7: After the last bit, a 20 µs end pause follows. When it finishes, the carrier comes back on, `done` pulses for exactly one cycle, and `frame_end` takes the absolute tick at which the pause finished.
- R8: Deadlines are compared wrap-safely, so a frame that crosses the 32-bit tick rollover keeps exact timing.
- R9: A start strobe received while `busy` is high is ignored and is not remembered after the frame ends.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `done` pulses, and it is low in that cycle.
- R11: `tick_now` advances by exactly one every `TICK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start strobe, used only when idle |
| frame_data | input | MAX_BITS | Frame word, bit 0 is sent first |
| frame_len | input | LEN_W | Number of bits to send, limited to MAX_BITS |
| last_end | input | TS_W | Tick timestamp of the end of the previous frame |
| ks_ready | input | 1 | Keystream bit available |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle pulse: keystream bit consumed |
| carrier_en | output | 1 | Carrier enable, low during pauses |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of the frame |
| frame_end | output | TS_W | Tick timestamp at which the last frame ended |
| tick_now | output | TS_W | Free-running tick counter |

## Verification
The case that is hardest to reach from the ports is a frame whose deadlines straddle the 32-bit tick rollover. A plain unsigned compare would stall there or fire early. The bench starts the tick counter just below the wrap point, using the reset-value parameter, so the first frames cross zero in the middle of a bit. It also holds `ks_ready` low past a bit's scheduled start, which shows that the pause end stays on the absolute deadline even when the bit starts late.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ON    = 2'd1,
      ST_PAUSE = 2'd2,
      ST_END   = 2'd3
   } ptx_state_e;

   // convert microseconds into ticks for a rate of num/den ticks per us
   function automatic int us_to_ticks(input int us, input int num, input int den);
      return (us * num) / den;
   endfunction

endpackage

// File: rtl/ptx_tick_gen.sv
module ptx_tick_gen #(
   parameter int          TICK_DIV  = 32,
   parameter int          TS_W      = 32,
   parameter logic [31:0] TICK_INIT = 32'd0
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] tick
);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         tick  <= TS_W'(TICK_INIT);
      end else if (pre_q == PRE_W'(TICK_DIV - 1)) begin
         pre_q <= '0;
         tick  <= tick + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   p_tick_step_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tick) |-> (tick == $past(tick) + 1'b1))
      else $error("tick moved by other than one");

endmodule

// File: rtl/ptx_deadline.sv
module ptx_deadline #(
   parameter int TS_W      = 32,
   parameter bit WRAP_SAFE = 1'b1
) (
   input  logic [TS_W-1:0] now,
   input  logic [TS_W-1:0] deadline,
   output logic            reached
);
   generate
      if (WRAP_SAFE) begin : g_wrap
         logic [TS_W-1:0] diff;
         assign diff    = now - deadline;
         assign reached = ~diff[TS_W-1];
      end else begin : g_plain
         assign reached = (now >= deadline);
      end
   endgenerate
endmodule

// File: rtl/ptx_shifter.sv
module ptx_shifter #(
   parameter int MAX_BITS = 32,
   parameter int LEN_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [MAX_BITS-1:0] word,
   input  logic [LEN_W-1:0]    len,
   input  logic                shift,
   output logic                cur_bit,
   output logic                empty
);
   logic [MAX_BITS-1:0] data_q;
   logic [LEN_W-1:0]    rem_q;
   logic [LEN_W-1:0]    len_clamped;

   assign len_clamped = (len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len;
   assign cur_bit     = data_q[0];
   assign empty       = (rem_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         rem_q  <= '0;
      end else if (load) begin
         data_q <= word;
         rem_q  <= len_clamped;
      end else if (shift && !empty) begin
         data_q <= data_q >> 1;
         rem_q  <= rem_q - 1'b1;
      end
   end

   p_len_clamp_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= LEN_W'(MAX_BITS))
      else $error("remaining bit count above limit");

endmodule

// File: rtl/ptx_pause_tx.sv
module ptx_pause_tx #(
   parameter int          MAX_BITS  = 32,
   parameter int          LEN_W     = $clog2(MAX_BITS) + 1,
   parameter int          TS_W      = 32,
   parameter int          TICK_DIV  = 32,
   parameter int          TICK_NUM  = 3,
   parameter int          TICK_DEN  = 2,
   parameter logic [31:0] TICK_INIT = 32'd0,
   parameter bit          WRAP_SAFE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MAX_BITS-1:0] frame_data,
   input  logic [LEN_W-1:0]    frame_len,
   input  logic [TS_W-1:0]     last_end,
   input  logic                ks_ready,
   input  logic                ks_bit,
   output logic                ks_adv,
   output logic                carrier_en,
   output logic                busy,
   output logic                done,
   output logic [TS_W-1:0]     frame_end,
   output logic [TS_W-1:0]     tick_now
);
   import ptx_pkg::*;

   localparam int T_PAUSE = us_to_ticks(20,  TICK_NUM, TICK_DEN);
   localparam int T_ONE   = us_to_ticks(100, TICK_NUM, TICK_DEN);
   localparam int T_ZERO  = us_to_ticks(60,  TICK_NUM, TICK_DEN);
   localparam int T_GAP   = us_to_ticks(220, TICK_NUM, TICK_DEN);

   initial begin : elab_checks
      assert (TICK_DIV >= 2) else $fatal(1, "TICK_DIV must be at least 2");
      assert (T_PAUSE > 0 && T_ZERO > T_PAUSE && T_ONE > T_ZERO)
         else $fatal(1, "tick rate gives unusable bit timing");
      assert (MAX_BITS <= (1 << LEN_W) - 1) else $fatal(1, "LEN_W too narrow");
      assert (TS_W <= 32) else $fatal(1, "TS_W above 32");
   end

   ptx_state_e      state_q;
   logic [TS_W-1:0] deadline_q;
   logic            air_q;
   logic            reached;
   logic            cur_bit;
   logic            empty;
   logic            load;
   logic            shift;
   logic            take;

   ptx_tick_gen #(.TICK_DIV(TICK_DIV), .TS_W(TS_W), .TICK_INIT(TICK_INIT)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick_now));

   ptx_deadline #(.TS_W(TS_W), .WRAP_SAFE(WRAP_SAFE)) u_cmp (
      .now(tick_now), .deadline(deadline_q), .reached(reached));

   ptx_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .word(frame_data), .len(frame_len),
      .shift(shift), .cur_bit(cur_bit), .empty(empty));

   assign load       = (state_q == ST_IDLE) && start;
   assign shift      = (state_q == ST_PAUSE) && reached;
   assign take       = (state_q == ST_ON) && reached && !empty && ks_ready;
   assign busy       = (state_q != ST_IDLE);
   assign carrier_en = (state_q != ST_PAUSE) && (state_q != ST_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         deadline_q <= '0;
         air_q      <= 1'b0;
         ks_adv     <= 1'b0;
         done       <= 1'b0;
         frame_end  <= '0;
      end else begin
         ks_adv <= take;
         done   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  deadline_q <= last_end + TS_W'(T_GAP);
                  state_q    <= ST_ON;
               end
            end
            ST_ON: begin
               if (reached && empty) begin
                  deadline_q <= deadline_q + TS_W'(T_PAUSE);
                  state_q    <= ST_END;
               end else if (take) begin
                  air_q      <= cur_bit ^ ks_bit;
                  deadline_q <= deadline_q + TS_W'(T_PAUSE);
                  state_q    <= ST_PAUSE;
               end
            end
            ST_PAUSE: begin
               if (reached) begin
                  deadline_q <= deadline_q + (air_q ? TS_W'(T_ONE - T_PAUSE)
                                                    : TS_W'(T_ZERO - T_PAUSE));
                  state_q    <= ST_ON;
               end
            end
            ST_END: begin
               if (reached) begin
                  frame_end <= deadline_q;
                  done      <= 1'b1;
                  state_q   <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_adv_ready_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ks_adv |-> $past(ks_ready))
      else $error("keystream advanced without ready");

   p_adv_in_pause_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ks_adv |-> !carrier_en)
      else $error("keystream advance outside a pause start");

   p_done_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   p_done_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("busy still high with done");

   p_off_only_busy_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_en |-> busy)
      else $error("carrier off while idle");

   p_start_ignored_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (done || $stable(frame_end)))
      else $error("start during busy disturbed the frame");

endmodule

// File: tb/tb_ptx_pause_tx.sv
module tb_ptx_pause_tx;
   localparam int MAXB  = 32;
   localparam int LW    = 6;
   localparam int TW    = 32;
   localparam int DIV   = 4;
   localparam int PAUSE = 30;
   localparam int ONE   = 150;
   localparam int ZERO  = 90;
   localparam int GAP   = 330;
   localparam logic [31:0] INIT = 32'hFFFF_FE00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [MAXB-1:0] frame_data = '0;
   logic [LW-1:0] frame_len = '0;
   logic [TW-1:0] last_end = '0;
   logic ks_ready = 1'b1;
   logic ks_bit;
   logic ks_adv, carrier_en, busy, done;
   logic [TW-1:0] frame_end, tick_now;

   int checks = 0;
   int fails = 0;
   int adv_cnt = 0;
   int ks_base = 0;
   int cycles = 0;
   logic [31:0] ks_word = '0;

   always #10 clk = ~clk;

   ptx_pause_tx #(.MAX_BITS(MAXB), .LEN_W(LW), .TS_W(TW), .TICK_DIV(DIV),
                  .TICK_NUM(3), .TICK_DEN(2), .TICK_INIT(INIT)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .frame_data(frame_data),
      .frame_len(frame_len), .last_end(last_end), .ks_ready(ks_ready),
      .ks_bit(ks_bit), .ks_adv(ks_adv), .carrier_en(carrier_en), .busy(busy),
      .done(done), .frame_end(frame_end), .tick_now(tick_now));

   assign ks_bit = ks_word[5'(adv_cnt - ks_base)];

   always @(negedge clk) if (ks_adv) adv_cnt <= adv_cnt + 1;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         fails = fails + 1;
         $display("FAIL R10 watchdog: act=hung exp=frame completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wait_carrier(input logic val);
      while (carrier_en !== val) @(negedge clk);
   endtask

   // one frame; stall holds ks_ready low until 10 ticks past the first bit start
   task automatic run_frame(input logic [31:0] data, input int len, input logic [31:0] keys,
                            input logic [31:0] base_ts, input bit stall, input bit poke);
      logic [31:0] exp_t;
      int nbits;
      nbits = (len > 32) ? 32 : len;
      ks_word = keys;
      ks_base = adv_cnt;
      if (stall) ks_ready = 1'b0;
      @(negedge clk);
      frame_data = data; frame_len = LW'(len); last_end = base_ts; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10 busy after start", busy, 1);
      exp_t = base_ts + GAP;
      for (int k = 0; k < nbits; k++) begin
         logic air;
         if (stall && k == 0) begin
            while (tick_now !== exp_t + 10) @(negedge clk);
            chk(carrier_en === 1'b1, "R6 no bit while not ready", carrier_en, 1);
            ks_ready = 1'b1;
         end
         wait_carrier(1'b0);
         if (!(stall && k == 0))
            chk(tick_now === exp_t, "R2/R4/R8 pause start tick", tick_now, exp_t);
         chk(ks_adv === 1'b1, "R6 advance with pause", ks_adv, 1);
         wait_carrier(1'b1);
         chk(tick_now === exp_t + PAUSE, "R3 pause end tick", tick_now, exp_t + PAUSE);
         air = data[k] ^ keys[k];
         exp_t = exp_t + (air ? ONE : ZERO);
         if (poke && k == 3) begin
            @(negedge clk);
            frame_data = '0; frame_len = LW'(1); last_end = tick_now; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      end
      wait_carrier(1'b0);
      chk(tick_now === exp_t, "R5/R7 end pause start", tick_now, exp_t);
      wait_carrier(1'b1);
      chk(tick_now === exp_t + PAUSE, "R7 end pause length", tick_now, exp_t + PAUSE);
      chk(done === 1'b1 && busy === 1'b0, "R7/R10 done pulse", {done, busy}, 2'b10);
      chk(frame_end === exp_t + PAUSE, "R7 frame_end", frame_end, exp_t + PAUSE);
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", done, 0);
      chk(busy === 1'b0, "R9 start not remembered", busy, 0);
      chk(adv_cnt - ks_base == nbits, "R5/R6 keystream count", adv_cnt - ks_base, nbits);
   endtask

   task automatic test_reset();
      chk(carrier_en === 1'b1 && busy === 1'b0 && done === 1'b0 && ks_adv === 1'b0,
          "R1 reset outputs", {carrier_en, busy, done, ks_adv}, 4'b1000);
      chk(frame_end === '0, "R1 frame_end", frame_end, 0);
      chk(tick_now === INIT, "R1 tick init", tick_now, INIT);
   endtask

   task automatic test_tick_rate();
      logic [31:0] t0;
      while (tick_now === INIT) @(negedge clk);
      t0 = tick_now;
      repeat (10 * DIV) @(negedge clk);
      chk(tick_now === t0 + 10, "R11 tick rate", tick_now, t0 + 10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_tick_rate();
      // R8: frame straddles the tick rollover
      run_frame(32'h0000_00A5, 8, 32'h0000_003C, tick_now, 1'b0, 1'b0);
      // chained from previous end, full length, start pulsed while busy (R9)
      run_frame(32'hDEAD_BEEF, 32, 32'h1234_5678, frame_end, 1'b0, 1'b1);
      // R5: zero length sends only the end pause
      run_frame(32'hFFFF_FFFF, 0, 32'h0, frame_end, 1'b0, 1'b0);
      // R5: length 40 limited to 32
      run_frame(32'h0F0F_3355, 40, 32'hFFFF_0000, frame_end, 1'b0, 1'b0);
      // R6: keystream not ready at bit start
      run_frame(32'h0000_0006, 3, 32'h0000_0005, frame_end, 1'b1, 1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule